// File: doc/BRIEF.md
# Infrared Run-Length Receiver

This block watches one demodulated infrared line from a remote control and turns it into a stream of run-length bytes. The line passes a two-flop synchronizer and an optional inverter, and is sampled once every `SAMPLE_DIV` clock cycles. A glitch filter then decides the accepted level. Every stretch of constant accepted level becomes one byte: the top bit carries the level and the low seven bits carry the length in samples. The bytes go into a small receive FIFO, which software drains through a register bus with separate read and write strobes.

A long silence closes a packet. The final space entry is written, a packet-end flag is raised, and the receiver goes quiet until the next mark. Three sources can raise the interrupt line: the FIFO reaching a programmable fill level, packet end, and FIFO overflow. Protocol decoding is left to software.

Top module: `ir_runlen_rx`

## Requirements
- R1: After reset every register reads zero, `irq` is low, the FIFO is empty and a FIFO read returns 0.
- R2: An entry has bit 7 = accepted level (1 = mark, 0 = space) and bits 6:0 = run length in samples. One sample is `SAMPLE_DIV` (64) clock cycles, so a level held for N*64 cycles gives length N.
- R3: Bit 2 of the line-control register (offset 0x10) inverts the input before sampling. With it set, a low input is a mark.
- R4: The filter threshold T is held in bits 7:2 of the timing register (0x34). A change of level is accepted only after the new level has lasted T+1 consecutive samples. Shorter pulses produce no entry and do not alter the lengths of the runs around them.
- R5: A run reaching 127 samples is written as a saturated entry (length 127). Counting then restarts for the same level, and the remainder is written as a further entry.
- R6: The idle threshold I (I ≥ 1) is held in bits 15:8 of the timing register. When a space has lasted I+1 samples, the entry {0, I+1} is written, status bit 1 (packet end) is set, and no more entries are written until the next mark. Idle time after enable is never recorded.
- R7: The FIFO holds 16 entries. A read of offset 0x20 returns the oldest entry and removes it. Status (0x30) bits 13:8 give the entry count.
- R8: An entry arriving while the FIFO is full is dropped and status bit 0 (overflow) is set. The stored entries are unchanged.
- R9: Status bits 0 and 1 are sticky. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R10: Status bit 4 (data available) is high exactly while the count is at least L+1, where L is held in bits 13:8 of the interrupt-enable register (0x2C).
- R11: `irq` is high exactly when some status flag (bit 0, 1 or 4) is set and the enable bit in the same position of register 0x2C is also set.
- R12: The receiver runs only while bits 1:0 and bits 5:4 of the control register (0x00) are both 3. Otherwise the FIFO is flushed and the sampling and run logic restart in the quiet state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_in | input | 1 | Demodulated infrared line |
| bus_addr | input | 6 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe; pops the FIFO at offset 0x20 |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Interrupt request |

## Verification
The embedded assertions are checked on every cycle. They cover FIFO count bounds, the overflow flag following a dropped entry, the flush while the receiver is disabled, the clearing of the packet-end flag, and the rule that no entry ever carries a zero length. Only the directed scenarios can show the run lengths that come out of real waveforms. These include rejected glitches, saturation at 127, inversion, the single closing idle entry, first-in first-out order, and where the data-available threshold lies.

// File: rtl/ir_runlen_rx.sv
module ir_runlen_rx #(
  parameter int SAMPLE_DIV = 64,
  parameter int FIFO_DEPTH = 16,
  parameter int LEN_W      = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ir_in,
  input  logic [5:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  input  logic        bus_rd,
  output logic [31:0] bus_rdata,
  output logic        irq
);
  localparam int DIV_W = $clog2(SAMPLE_DIV);
  localparam int PTR_W = $clog2(FIFO_DEPTH);
  localparam int CNT_W = PTR_W + 1;
  localparam int ENT_W = LEN_W + 1;
  localparam logic [LEN_W-1:0] LEN_MAX = {LEN_W{1'b1}};
  localparam logic [5:0] A_CTRL = 6'h00, A_LINE = 6'h10, A_FIFO = 6'h20,
                         A_IEN  = 6'h2C, A_STAT = 6'h30, A_TIME = 6'h34;

  logic [1:0] en_q, mode_q;
  logic       inv_q, ie_ovf, ie_pkt, ie_da;
  logic [5:0] lvl_m1, flt_thr;
  logic [7:0] idle_thr;
  logic       ovf_f, pkt_f;

  logic active;
  assign active = (&en_q) && (&mode_q);

  logic wr_ctrl, wr_line, wr_ien, wr_stat, wr_time;
  assign wr_ctrl = bus_wr && bus_addr == A_CTRL;
  assign wr_line = bus_wr && bus_addr == A_LINE;
  assign wr_ien  = bus_wr && bus_addr == A_IEN;
  assign wr_stat = bus_wr && bus_addr == A_STAT;
  assign wr_time = bus_wr && bus_addr == A_TIME;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0; mode_q <= '0; inv_q <= 1'b0;
      ie_ovf <= 1'b0; ie_pkt <= 1'b0; ie_da <= 1'b0; lvl_m1 <= '0;
      flt_thr <= '0; idle_thr <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q   <= bus_wdata[1:0];
        mode_q <= bus_wdata[5:4];
      end
      if (wr_line) inv_q <= bus_wdata[2];
      if (wr_ien) begin
        ie_ovf <= bus_wdata[0];
        ie_pkt <= bus_wdata[1];
        ie_da  <= bus_wdata[4];
        lvl_m1 <= bus_wdata[13:8];
      end
      if (wr_time) begin
        flt_thr  <= bus_wdata[7:2];
        idle_thr <= bus_wdata[15:8];
      end
    end
  end

  logic [1:0] sync_q;
  logic       samp;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], ir_in};
  assign samp = sync_q[1] ^ inv_q;

  logic [DIV_W-1:0] div_q;
  logic             tick;
  assign tick = active && div_q == DIV_W'(SAMPLE_DIV - 1);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       div_q <= '0;
    else if (!active) div_q <= '0;
    else if (tick)    div_q <= '0;
    else              div_q <= div_q + 1'b1;

  logic             flt_q, lvl_q, quiet_q;
  logic [5:0]       dcnt_q;
  logic [LEN_W-1:0] run_q;
  logic [8:0]       idle_q;
  logic             chg, nf, idle_hit;
  logic             push, pkt_set;
  logic [ENT_W-1:0] pdata;

  assign chg      = tick && samp != flt_q && dcnt_q >= flt_thr;
  assign nf       = chg ? samp : flt_q;
  assign idle_hit = (idle_q + 9'd1) > {1'b0, idle_thr};
  assign pkt_set  = tick && !quiet_q && nf == lvl_q && !lvl_q && idle_hit;

  always_comb begin
    push  = 1'b0;
    pdata = '0;
    if (tick && !quiet_q) begin
      if (nf != lvl_q) begin
        push  = run_q != '0;
        pdata = {lvl_q, run_q};
      end else if (!lvl_q && idle_hit) begin
        push  = 1'b1;
        pdata = {1'b0, LEN_W'(run_q + 1'b1)};
      end else if (run_q == LEN_MAX - 1'b1) begin
        push  = 1'b1;
        pdata = {lvl_q, LEN_MAX};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || !active) begin
      flt_q <= 1'b0; dcnt_q <= '0; lvl_q <= 1'b0;
      run_q <= '0; idle_q <= '0; quiet_q <= 1'b1;
    end else if (tick) begin
      if (samp == flt_q)  dcnt_q <= '0;
      else if (chg) begin flt_q <= samp; dcnt_q <= '0; end
      else                dcnt_q <= dcnt_q + 1'b1;

      if (quiet_q) begin
        if (nf) begin
          quiet_q <= 1'b0; lvl_q <= 1'b1; run_q <= LEN_W'(1); idle_q <= '0;
        end
      end else if (nf != lvl_q) begin
        lvl_q  <= nf;
        run_q  <= LEN_W'(1);
        idle_q <= nf ? 9'd0 : 9'd1;
      end else if (!lvl_q && idle_hit) begin
        quiet_q <= 1'b1; run_q <= '0; idle_q <= '0;
      end else begin
        run_q <= (run_q == LEN_MAX - 1'b1) ? '0 : run_q + 1'b1;
        if (!lvl_q) idle_q <= idle_q + 9'd1;
      end
    end
  end

  logic [ENT_W-1:0] mem [FIFO_DEPTH];
  logic [PTR_W-1:0] wp_q, rp_q;
  logic [CNT_W-1:0] cnt_q;
  logic             full, pop, do_push, ovf_set;

  assign full    = cnt_q == CNT_W'(FIFO_DEPTH);
  assign pop     = bus_rd && bus_addr == A_FIFO && cnt_q != '0;
  assign do_push = push && (!full || pop);
  assign ovf_set = push && full && !pop;

  always_ff @(posedge clk)
    if (do_push) mem[wp_q] <= pdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || !active) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= wp_q + 1'b1;
      if (pop)     rp_q <= rp_q + 1'b1;
      cnt_q <= cnt_q + CNT_W'(do_push) - CNT_W'(pop);
    end
  end

  logic da;
  assign da = {1'b0, 6'(cnt_q)} >= ({1'b0, lvl_m1} + 7'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_f <= 1'b0; pkt_f <= 1'b0;
    end else begin
      ovf_f <= ovf_set | (ovf_f & ~(wr_stat & bus_wdata[0]));
      pkt_f <= pkt_set | (pkt_f & ~(wr_stat & bus_wdata[1]));
    end
  end

  assign irq = (ovf_f & ie_ovf) | (pkt_f & ie_pkt) | (da & ie_da);

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = {26'd0, mode_q, 2'd0, en_q};
      A_LINE:  bus_rdata = {29'd0, inv_q, 2'd0};
      A_FIFO:  bus_rdata = (cnt_q != '0) ? 32'(mem[rp_q]) : 32'd0;
      A_IEN:   bus_rdata = {18'd0, lvl_m1, 3'd0, ie_da, 2'd0, ie_pkt, ie_ovf};
      A_STAT:  bus_rdata = {18'd0, 6'(cnt_q), 3'd0, da, 2'd0, pkt_f, ovf_f};
      A_TIME:  bus_rdata = {16'd0, idle_thr, flt_thr, 2'd0};
      default: bus_rdata = 32'd0;
    endcase
  end

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(FIFO_DEPTH));

  // R8
  drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> ovf_f);

  // R12
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> cnt_q == '0);

  // R9
  pkt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && bus_wdata[1] && !pkt_set) |=> !pkt_f);

  // R2
  len_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> pdata[LEN_W-1:0] != '0);
endmodule

// File: tb/sim_ir_runlen_rx.sv
module sim_ir_runlen_rx;
  logic clk = 0, rst_n = 0, ir_in = 0;
  logic [5:0] bus_addr = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic irq;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  ir_runlen_rx u0 (.clk(clk), .rst_n(rst_n), .ir_in(ir_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .irq(irq));

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] v);
    @(negedge clk); bus_addr = a; bus_rd = 1; #1 v = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic line(logic lv, int n);
    @(negedge clk); ir_in = lv;
    repeat (n * 64) @(negedge clk);
  endtask

  task automatic setup(logic inv, int fthr, int ithr, logic [31:0] ien);
    wr(6'h00, 0);
    ir_in = inv;
    wr(6'h10, {29'd0, inv, 2'd0});
    wr(6'h34, (ithr << 8) | (fthr << 2));
    wr(6'h2C, ien);
    wr(6'h30, 32'h13);
    wr(6'h00, 32'h33);
    line(inv, 5);
  endtask

  function automatic logic [31:0] cnt_of(logic [31:0] s);
    return {26'd0, s[13:8]};
  endfunction

  task automatic t_reset;
    logic [31:0] v;
    rd(6'h30, v); chk("R1 status", v, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    rd(6'h20, v); chk("R1 fifo", v, 0);
    rd(6'h00, v); chk("R1 ctrl", v, 0);
  endtask

  task automatic t_basic;
    logic [31:0] v;
    setup(0, 0, 20, 0);
    line(0, 30);
    rd(6'h30, v); chk("R6 leading idle", cnt_of(v), 0);
    line(1, 10); line(0, 30);
    rd(6'h30, v); chk("R7 count", cnt_of(v), 2);
    chk("R6 packet end", {31'd0, v[1]}, 1);
    rd(6'h20, v); chk("R2 mark entry", v, 32'h8A);
    rd(6'h20, v); chk("R6 idle entry", v, 32'h15);
    rd(6'h30, v); chk("R7 empty", cnt_of(v), 0);
    line(1, 3); line(0, 30);
    rd(6'h30, v); chk("R6 quiet count", cnt_of(v), 2);
    rd(6'h20, v); chk("R6 no idle before mark", v, 32'h83);
  endtask

  task automatic t_invert;
    logic [31:0] v;
    setup(1, 0, 20, 0);
    line(0, 5); line(1, 30);
    rd(6'h20, v); chk("R3 inverted mark", v, 32'h85);
    rd(6'h20, v); chk("R3 inverted space", v, 32'h15);
  endtask

  task automatic t_filter;
    logic [31:0] v;
    setup(0, 2, 20, 0);
    line(1, 2); line(0, 30);
    rd(6'h30, v); chk("R4 glitch rejected", cnt_of(v), 0);
    line(1, 8); line(0, 40);
    rd(6'h30, v); chk("R4 count", cnt_of(v), 2);
    rd(6'h20, v); chk("R4 length kept", v, 32'h88);
    rd(6'h20, v); chk("R4 idle entry", v, 32'h15);
  endtask

  task automatic t_sat;
    logic [31:0] v;
    setup(0, 0, 20, 0);
    line(1, 130); line(0, 30);
    rd(6'h30, v); chk("R5 count", cnt_of(v), 3);
    rd(6'h20, v); chk("R5 saturated", v, 32'hFF);
    rd(6'h20, v); chk("R5 remainder", v, 32'h83);
    rd(6'h20, v); chk("R5 idle", v, 32'h15);
  endtask

  task automatic t_da_irq;
    logic [31:0] v;
    setup(0, 0, 20, 32'h0310);
    line(1, 2); line(0, 2); line(1, 2); line(0, 30);
    rd(6'h30, v); chk("R10 count", cnt_of(v), 4);
    chk("R10 da at level", {31'd0, v[4]}, 1);
    chk("R11 irq da", {31'd0, irq}, 1);
    rd(6'h20, v);
    rd(6'h30, v); chk("R10 da below level", {31'd0, v[4]}, 0);
    chk("R11 irq masked pkt", {31'd0, irq}, 0);
    wr(6'h2C, 32'h0302);
    #1 chk("R11 irq pkt", {31'd0, irq}, 1);
  endtask

  task automatic t_ovf;
    logic [31:0] v;
    setup(0, 0, 20, 32'h01);
    for (int i = 0; i < 9; i++) begin line(1, 2); line(0, 2); end
    line(0, 30);
    rd(6'h30, v); chk("R8 full count", cnt_of(v), 16);
    chk("R8 overflow flag", {31'd0, v[0]}, 1);
    chk("R11 irq ovf", {31'd0, irq}, 1);
    for (int i = 0; i < 16; i++) begin
      rd(6'h20, v); chk("R8 order kept", v, (i % 2 == 0) ? 32'h82 : 32'h02);
    end
    rd(6'h30, v); chk("R7 drained", cnt_of(v), 0);
    wr(6'h30, 0);
    rd(6'h30, v); chk("R9 zero write keeps", v & 32'h3, 3);
    wr(6'h30, 1);
    rd(6'h30, v); chk("R9 clear ovf", v & 32'h3, 2);
    chk("R11 irq cleared", {31'd0, irq}, 0);
    wr(6'h30, 2);
    rd(6'h30, v); chk("R9 clear pkt", v, 0);
  endtask

  task automatic t_enable;
    logic [31:0] v;
    setup(0, 0, 20, 0);
    line(1, 4); line(0, 30);
    rd(6'h30, v); chk("R12 filled", cnt_of(v), 2);
    wr(6'h00, 0);
    rd(6'h30, v); chk("R12 flushed", cnt_of(v), 0);
    wr(6'h00, 32'h03);
    line(1, 4); line(0, 30);
    rd(6'h30, v); chk("R12 wrong mode idle", cnt_of(v), 0);
    wr(6'h00, 32'h33);
    line(1, 6); line(0, 30);
    rd(6'h20, v); chk("R12 restarted", v, 32'h86);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_basic;
    t_invert;
    t_filter;
    t_sat;
    t_da_irq;
    t_ovf;
    t_enable;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule